// File: doc/BRIEF.md
# Shared Interrupt Source Router

The router holds a bank of external interrupt sources (a multiple of 8, up to 256). Every source carries an enable bit, a pending bit, a pin selection and a core selection. Pending sources that are enabled drive one level output per core and per CPU interrupt pin. Several sources can land on the same core and pin; they are OR-combined there. No priority or vectoring is applied.

Pending follows a level-sensitive hardware input. It can also be forced to 1 or 0 by software through a wedge register. Software uses a simple word bus to:
- set and clear enables one bit per source;
- read pending and enable state back one bit per source;
- program the pin and core selection of each source;
- read a configuration word that reports the source and core counts.

Top module: `irq_router`

## Requirements
- R1: After synchronous reset every source is disabled and not pending. Each pin selection reads 0x80000000 (route flag set, pin 0). Each core selection reads 0, meaning unmapped. All outputs are low.
- R2: A write to the enable-set range (byte 0x1C0 + k) sets the enable of source 8k+i for every 1 in data bit i. A write to the enable-clear range (byte 0x180 + k) clears it the same way. A 0 bit leaves the enable unchanged. The access covers 8, 16 or 32 bits for bus_size 0, 1 and 2 or 3.
- R3: Reads of the pending range (0x100 + k) and the enable range (0x140 + k) return the bits of sources 8k.. packed from bit 0. An access that would reach past the last source returns 0 on a read. On a write to the set or clear range it changes nothing.
- R4: A write to the wedge word (0x004) forces the pending bit of the source numbered in data[30:0] to the value of data[31]. A source number at or above the source count changes nothing.
- R5: The pin-selection word of source s is at 0x400 + 4s. A write stores data[31] and data[5:0] only, and reads return them in the same positions. The write is discarded when data[5:0] exceeds N_PIN-1.
- R6: The core-selection word of source s is at 0x800 + 32s. A write stores the index of the lowest set data bit; zero means unmapped. The write is discarded when that index is N_CORE or more. Reads return 1 shifted left by the stored index, or 0 when unmapped.
- R7: Output bit c*N_PIN+p is the OR of pending over all sources that are enabled, mapped to core c and mapped to pin p. It is registered, so it reflects the source state one clock after that state changes.
- R8: Each clock, a source whose hardware input differs from its previous sampled value takes that input level as pending. This happens whether the source is enabled or not. A wedge write in the same clock takes precedence.
- R9: The configuration word at 0x000 returns (N_SRC/8)-1 in bits [7:0] and N_CORE in bits [15:8]. All other bits read 0.
- R10: Read data appears on bus_rdata one clock after bus_re and holds until the next read. Addresses that decode to no register read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | 14 | Byte address |
| bus_size | input | 2 | Access width for bit ranges: 0 = 8, 1 = 16, 2/3 = 32 bits |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| hw_irq | input | N_SRC | Level-sensitive source inputs |
| irq_out | output | N_CORE*N_PIN | Per-core, per-pin level outputs |

## Verification
A bus write or a hardware input change alters source state at the next rising edge. The outputs follow at the edge after that, so the bench samples them two falling edges after driving the stimulus. Read data is captured at the edge that sees bus_re and is sampled at the following falling edge. Every output check compares the full output vector with an OR computed from a bench-side copy of the enable, pending and mapping state. That copy is updated only from the requirement text.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  localparam int ADDR_W  = 14;
  localparam int PIN_FW  = 6;
  localparam int CIDX_W  = 5;
  localparam int MAX_SRC = 256;

  localparam logic [ADDR_W-1:0] A_CFG   = 14'h0000;
  localparam logic [ADDR_W-1:0] A_WEDGE = 14'h0004;
  localparam logic [ADDR_W-1:0] A_PEND  = 14'h0100;
  localparam logic [ADDR_W-1:0] A_EN    = 14'h0140;
  localparam logic [ADDR_W-1:0] A_CLR   = 14'h0180;
  localparam logic [ADDR_W-1:0] A_SET   = 14'h01C0;
  localparam logic [ADDR_W-1:0] A_PIN   = 14'h0400;
  localparam logic [ADDR_W-1:0] A_CORE  = 14'h0800;

  // Position of the lowest set bit; 32 when the word is zero.
  function automatic logic [5:0] low_bit_idx(input logic [31:0] v);
    logic [5:0] r;
    r = 6'd32;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = 6'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
  import irq_router_pkg::*;
#(
  parameter int N_SRC = 16,
  parameter int SRC_W = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [N_SRC-1:0]               hw_irq,
  input  logic [N_SRC-1:0]               set_en,
  input  logic [N_SRC-1:0]               clr_en,
  input  logic                           wedge_we,
  input  logic                           wedge_val,
  input  logic [SRC_W-1:0]               wedge_src,
  input  logic [SRC_W-1:0]               map_src,
  input  logic                           pin_we,
  input  logic [PIN_FW:0]                pin_wdata,
  input  logic                           core_we,
  input  logic [CIDX_W:0]                core_wdata,
  output logic [N_SRC-1:0]               en_vec,
  output logic [N_SRC-1:0]               pend_vec,
  output logic [N_SRC-1:0]               hw_prev,
  output logic [N_SRC-1:0][PIN_FW:0]     pin_map,
  output logic [N_SRC-1:0][CIDX_W:0]     core_map
);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_vec   <= '0;
      pend_vec <= '0;
      hw_prev  <= '0;
      for (int s = 0; s < N_SRC; s++) begin
        pin_map[s]  <= {1'b1, {PIN_FW{1'b0}}};
        core_map[s] <= '0;
      end
    end else begin
      hw_prev <= hw_irq;
      for (int s = 0; s < N_SRC; s++) begin
        if (set_en[s])      en_vec[s] <= 1'b1;
        else if (clr_en[s]) en_vec[s] <= 1'b0;

        // software force wins over a same-cycle input change
        if (wedge_we && wedge_src == SRC_W'(s))
          pend_vec[s] <= wedge_val;
        else if (hw_irq[s] != hw_prev[s])
          pend_vec[s] <= hw_irq[s];

        if (pin_we && map_src == SRC_W'(s))  pin_map[s]  <= pin_wdata;
        if (core_we && map_src == SRC_W'(s)) core_map[s] <= core_wdata;
      end
    end
  end

endmodule

// File: rtl/irq_combine.sv
module irq_combine
  import irq_router_pkg::*;
#(
  parameter int N_SRC  = 16,
  parameter int N_CORE = 2,
  parameter int N_PIN  = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [N_SRC-1:0]           en_vec,
  input  logic [N_SRC-1:0]           pend_vec,
  input  logic [N_SRC-1:0][PIN_FW:0] pin_map,
  input  logic [N_SRC-1:0][CIDX_W:0] core_map,
  output logic [N_CORE*N_PIN-1:0]    irq_out
);

  localparam int N_OUT = N_CORE * N_PIN;

  logic [N_SRC-1:0] live;
  logic [N_OUT-1:0] out_d;

  assign live = en_vec & pend_vec;

  for (genvar c = 0; c < N_CORE; c++) begin : g_core
    for (genvar p = 0; p < N_PIN; p++) begin : g_pin
      logic [N_SRC-1:0] hit;
      for (genvar s = 0; s < N_SRC; s++) begin : g_src
        assign hit[s] = live[s] & core_map[s][CIDX_W] &
                        (core_map[s][CIDX_W-1:0] == CIDX_W'(c)) &
                        (pin_map[s][PIN_FW-1:0] == PIN_FW'(p));
      end
      assign out_d[c*N_PIN+p] = |hit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_out <= '0;
    else     irq_out <= out_d;
  end

endmodule

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_router_pkg::*;
#(
  parameter int N_SRC  = 16,
  parameter int N_CORE = 2,
  parameter int N_PIN  = 6,
  parameter int SRC_W  = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_we,
  input  logic                       bus_re,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [1:0]                 bus_size,
  input  logic [31:0]                bus_wdata,
  input  logic [N_SRC-1:0]           en_vec,
  input  logic [N_SRC-1:0]           pend_vec,
  input  logic [N_SRC-1:0][PIN_FW:0] pin_map,
  input  logic [N_SRC-1:0][CIDX_W:0] core_map,
  output logic [N_SRC-1:0]           set_en,
  output logic [N_SRC-1:0]           clr_en,
  output logic                       wedge_we,
  output logic                       wedge_val,
  output logic [SRC_W-1:0]           wedge_src,
  output logic [SRC_W-1:0]           map_src,
  output logic                       pin_we,
  output logic [PIN_FW:0]            pin_wdata,
  output logic                       core_we,
  output logic [CIDX_W:0]            core_wdata,
  output logic [31:0]                bus_rdata
);

  localparam logic [7:0]        INT_FIELD  = 8'(N_SRC / 8 - 1);
  localparam logic [7:0]        CORE_FIELD = 8'(N_CORE);
  localparam logic [PIN_FW-1:0] MAX_PIN    = PIN_FW'(N_PIN - 1);

  logic [5:0]             nbits;
  logic [31:0]            wmask;
  logic [7:0]             sbase;
  logic                   fit;
  logic                   in_pend, in_en, in_clr, in_set, in_pin, in_core;
  logic [ADDR_W-1:0]      core_off;
  logic [7:0]             pin_idx, core_idx;
  logic                   pin_ok, core_ok;
  logic [SRC_W-1:0]       pin_s, core_s;
  logic [MAX_SRC+31:0]    wide;
  logic [N_SRC+31:0]      pend_sh, en_sh;
  logic [5:0]             lowbit;
  logic [31:0]            rd_d;

  always_comb begin
    case (bus_size)
      2'd0:    nbits = 6'd8;
      2'd1:    nbits = 6'd16;
      default: nbits = 6'd32;
    endcase
    wmask = (nbits == 6'd32) ? 32'hFFFF_FFFF : ((32'h1 << nbits) - 32'h1);
    sbase = {bus_addr[4:0], 3'b000};
    fit   = ({2'b00, sbase} + {4'b0000, nbits}) <= 10'(N_SRC);

    in_pend = bus_addr[ADDR_W-1:5] == A_PEND[ADDR_W-1:5];
    in_en   = bus_addr[ADDR_W-1:5] == A_EN[ADDR_W-1:5];
    in_clr  = bus_addr[ADDR_W-1:5] == A_CLR[ADDR_W-1:5];
    in_set  = bus_addr[ADDR_W-1:5] == A_SET[ADDR_W-1:5];

    in_pin   = bus_addr[ADDR_W-1:10] == A_PIN[ADDR_W-1:10];
    pin_idx  = bus_addr[9:2];
    core_off = bus_addr - A_CORE;
    in_core  = (bus_addr >= A_CORE) && !core_off[ADDR_W-1];
    core_idx = core_off[12:5];
    pin_ok   = {1'b0, pin_idx}  < 9'(N_SRC);
    core_ok  = {1'b0, core_idx} < 9'(N_SRC);
    pin_s    = pin_idx[SRC_W-1:0];
    core_s   = core_idx[SRC_W-1:0];

    wide    = {{MAX_SRC{1'b0}}, bus_wdata & wmask} << sbase;
    pend_sh = {32'b0, pend_vec} >> sbase;
    en_sh   = {32'b0, en_vec} >> sbase;
    lowbit  = low_bit_idx(bus_wdata);

    set_en    = (bus_we && in_set && fit) ? wide[N_SRC-1:0] : '0;
    clr_en    = (bus_we && in_clr && fit) ? wide[N_SRC-1:0] : '0;
    wedge_we  = bus_we && (bus_addr == A_WEDGE) && (bus_wdata[30:0] < 31'(N_SRC));
    wedge_val = bus_wdata[31];
    wedge_src = bus_wdata[SRC_W-1:0];
    map_src   = in_pin ? pin_s : core_s;
    pin_we    = bus_we && in_pin && pin_ok && (bus_wdata[PIN_FW-1:0] <= MAX_PIN);
    pin_wdata = {bus_wdata[31], bus_wdata[PIN_FW-1:0]};
    core_we   = bus_we && in_core && core_ok &&
                ((bus_wdata == 32'h0) || (lowbit < 6'(N_CORE)));
    core_wdata = (bus_wdata == 32'h0) ? '0 : {1'b1, lowbit[CIDX_W-1:0]};

    if (bus_addr == A_CFG)
      rd_d = {16'h0000, CORE_FIELD, INT_FIELD};
    else if (in_pend && fit)
      rd_d = pend_sh[31:0] & wmask;
    else if (in_en && fit)
      rd_d = en_sh[31:0] & wmask;
    else if (in_pin && pin_ok)
      rd_d = {pin_map[pin_s][PIN_FW], 25'b0, pin_map[pin_s][PIN_FW-1:0]};
    else if (in_core && core_ok)
      rd_d = core_map[core_s][CIDX_W] ? (32'h1 << core_map[core_s][CIDX_W-1:0]) : 32'h0;
    else
      rd_d = 32'h0;
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_d;
  end

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int N_SRC  = 16,
  parameter int N_CORE = 2,
  parameter int N_PIN  = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_we,
  input  logic                     bus_re,
  input  logic [13:0]              bus_addr,
  input  logic [1:0]               bus_size,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  input  logic [N_SRC-1:0]         hw_irq,
  output logic [N_CORE*N_PIN-1:0]  irq_out
);

  localparam int SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [N_SRC-1:0]           set_en, clr_en;
  logic                       wedge_we, wedge_val;
  logic [SRC_W-1:0]           wedge_src, map_src;
  logic                       pin_we, core_we;
  logic [PIN_FW:0]            pin_wdata;
  logic [CIDX_W:0]            core_wdata;
  logic [N_SRC-1:0]           en_vec, pend_vec, hw_prev;
  logic [N_SRC-1:0][PIN_FW:0] pin_map;
  logic [N_SRC-1:0][CIDX_W:0] core_map;

  irq_bus_decode #(.N_SRC(N_SRC), .N_CORE(N_CORE), .N_PIN(N_PIN), .SRC_W(SRC_W)) i_dec (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .en_vec(en_vec), .pend_vec(pend_vec),
    .pin_map(pin_map), .core_map(core_map), .set_en(set_en), .clr_en(clr_en),
    .wedge_we(wedge_we), .wedge_val(wedge_val), .wedge_src(wedge_src), .map_src(map_src),
    .pin_we(pin_we), .pin_wdata(pin_wdata), .core_we(core_we), .core_wdata(core_wdata),
    .bus_rdata(bus_rdata)
  );

  irq_src_bank #(.N_SRC(N_SRC), .SRC_W(SRC_W)) i_bank (
    .clk(clk), .rst(rst), .hw_irq(hw_irq), .set_en(set_en), .clr_en(clr_en),
    .wedge_we(wedge_we), .wedge_val(wedge_val), .wedge_src(wedge_src), .map_src(map_src),
    .pin_we(pin_we), .pin_wdata(pin_wdata), .core_we(core_we), .core_wdata(core_wdata),
    .en_vec(en_vec), .pend_vec(pend_vec), .hw_prev(hw_prev),
    .pin_map(pin_map), .core_map(core_map)
  );

  irq_combine #(.N_SRC(N_SRC), .N_CORE(N_CORE), .N_PIN(N_PIN)) i_comb (
    .clk(clk), .rst(rst), .en_vec(en_vec), .pend_vec(pend_vec),
    .pin_map(pin_map), .core_map(core_map), .irq_out(irq_out)
  );

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
  import irq_router_pkg::*;
#(
  parameter int N_SRC  = 16,
  parameter int N_CORE = 2,
  parameter int N_PIN  = 6
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    bus_we,
  input logic                    bus_re,
  input logic [13:0]             bus_addr,
  input logic [31:0]             bus_wdata,
  input logic [31:0]             bus_rdata,
  input logic [N_SRC-1:0]        hw_irq,
  input logic [N_CORE*N_PIN-1:0] irq_out,
  input logic [N_SRC-1:0]        en_vec,
  input logic [N_SRC-1:0]        pend_vec,
  input logic [N_SRC-1:0]        hw_prev
);

  localparam int SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam logic [31:0] CFG_WORD = {16'h0000, 8'(N_CORE), 8'(N_SRC / 8 - 1)};

  AST_OUT_LOW_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> irq_out == '0);  // R1

  AST_EN_HOLDS_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !bus_we |=> $stable(en_vec));  // R2

  AST_WEDGE_FORCES_SET: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_WEDGE && bus_wdata[31] && bus_wdata[30:0] < 31'(N_SRC))
    |=> pend_vec[$past(bus_wdata[SRC_W-1:0])]);  // R4

  AST_OUT_NEEDS_LIVE_SRC: assert property (@(posedge clk) disable iff (rst)
    (irq_out != '0) |-> ($past(en_vec & pend_vec) != '0));  // R7

  AST_PEND_HOLDS_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!bus_we && hw_irq == hw_prev) |=> $stable(pend_vec));  // R8

  AST_CFG_READBACK: assert property (@(posedge clk) disable iff (rst)
    (bus_re && bus_addr == A_CFG) |=> bus_rdata == CFG_WORD);  // R9

endmodule

bind irq_router irq_router_chk #(.N_SRC(N_SRC), .N_CORE(N_CORE), .N_PIN(N_PIN)) i_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_irq(hw_irq), .irq_out(irq_out),
  .en_vec(en_vec), .pend_vec(pend_vec), .hw_prev(hw_prev)
);

// File: tb/test_irq_router.sv
`timescale 1ns/100ps
module test_irq_router;

  localparam int NS = 16;
  localparam int NC = 2;
  localparam int NP = 6;
  localparam int NO = NC * NP;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_we = 1'b0;
  logic          bus_re = 1'b0;
  logic [13:0]   bus_addr = '0;
  logic [1:0]    bus_size = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NS-1:0] hw_irq = '0;
  logic [NO-1:0] irq_out;

  int tests = 0;
  int fails = 0;

  logic [NS-1:0] m_en, m_pend;
  logic          m_pflag [NS];
  int            m_pin [NS];
  logic          m_cv [NS];
  int            m_core [NS];

  always #2.5 clk = ~clk;

  irq_router #(.N_SRC(NS), .N_CORE(NC), .N_PIN(NP)) i_irq_router (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hw_irq(hw_irq), .irq_out(irq_out)
  );

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [13:0] a, input logic [31:0] d, input logic [1:0] sz);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [13:0] a, input logic [1:0] sz, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a; bus_size = sz;
    @(negedge clk);
    bus_re = 1'b0;
    check(bus_rdata == exp, tag, bus_rdata, exp);
  endtask

  function automatic logic [NO-1:0] exp_out();
    logic [NO-1:0] r = '0;
    for (int s = 0; s < NS; s++)
      if (m_en[s] && m_pend[s] && m_cv[s]) r[m_core[s]*NP + m_pin[s]] = 1'b1;
    return r;
  endfunction

  task automatic check_out(input string tag);
    logic [NO-1:0] e;
    @(negedge clk);
    e = exp_out();
    check(irq_out == e, tag, 32'(irq_out), 32'(e));
  endtask

  task automatic set_hw(input int s, input logic v);
    @(negedge clk);
    if (hw_irq[s] != v) m_pend[s] = v;
    hw_irq[s] = v;
    @(negedge clk);
  endtask

  function automatic logic [13:0] pin_a(input int s);  return 14'(14'h400 + 4 * s);  endfunction
  function automatic logic [13:0] core_a(input int s); return 14'(14'h800 + 32 * s); endfunction

  task automatic map_src(input int s, input int p, input int c);
    wr(pin_a(s), 32'h8000_0000 | 32'(p), 2'd2);
    m_pflag[s] = 1'b1; m_pin[s] = p;
    wr(core_a(s), 32'h1 << c, 2'd2);
    m_cv[s] = 1'b1; m_core[s] = c;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    m_en = '0; m_pend = '0;
    for (int s = 0; s < NS; s++) begin
      m_pflag[s] = 1'b1; m_pin[s] = 0; m_cv[s] = 1'b0; m_core[s] = 0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check_out("R1 outputs");
    rd(14'h140, 2'd1, 32'h0, "R1 enable");
    rd(14'h100, 2'd1, 32'h0, "R1 pending");
    rd(pin_a(0), 2'd2, 32'h8000_0000, "R1 pin map 0");
    rd(pin_a(15), 2'd2, 32'h8000_0000, "R1 pin map 15");
    rd(core_a(15), 2'd2, 32'h0, "R1 core map 15");

    // R9 configuration, R10 unmapped address
    rd(14'h0000, 2'd2, 32'h0000_0201, "R9 config");
    rd(14'h0008, 2'd2, 32'h0, "R10 unmapped");

    // mapping sweep with readback
    for (int s = 0; s < NS; s++) begin
      map_src(s, s % NP, s % NC);
      rd(pin_a(s), 2'd2, 32'h8000_0000 | 32'(s % NP), "R5 pin readback");
      rd(core_a(s), 2'd2, 32'h1 << (s % NC), "R6 core readback");
    end

    // R5 pin out of range discarded, flag bit kept as written
    wr(pin_a(3), 32'h0000_0006, 2'd2);
    rd(pin_a(3), 2'd2, 32'h8000_0003, "R5 pin reject");
    wr(pin_a(3), 32'h7FFF_FFC5, 2'd2);
    m_pflag[3] = 1'b0; m_pin[3] = 5;
    rd(pin_a(3), 2'd2, 32'h0000_0005, "R5 pin store fields");

    // R6 core selection
    wr(core_a(4), 32'h4, 2'd2);
    rd(core_a(4), 2'd2, 32'h1, "R6 core reject");
    wr(core_a(4), 32'h6, 2'd2);
    m_core[4] = 1;
    rd(core_a(4), 2'd2, 32'h2, "R6 lowest bit");
    wr(core_a(4), 32'h0, 2'd2);
    m_cv[4] = 1'b0;
    rd(core_a(4), 2'd2, 32'h0, "R6 unmapped");

    // R2 enable set and clear
    wr(14'h1C0, 32'hA5, 2'd0); m_en[7:0] = 8'hA5;
    wr(14'h1C1, 32'h03, 2'd0); m_en[9:8] = 2'b11;
    wr(14'h180, 32'h04, 2'd0); m_en[2] = 1'b0;
    rd(14'h140, 2'd1, 32'(m_en), "R2 enable bits");
    // R3 rejects and packing
    wr(14'h1C1, 32'hFFFF, 2'd1);
    rd(14'h140, 2'd1, 32'(m_en), "R3 oversize write ignored");
    rd(14'h140, 2'd2, 32'h0, "R3 oversize read");
    rd(14'h101, 2'd1, 32'h0, "R3 offset oversize read");
    rd(14'h141, 2'd0, 32'(m_en[15:8]), "R3 upper byte");

    // R8 hardware inputs, enabled or not
    for (int s = 0; s < NS; s++) begin
      set_hw(s, 1'b1);
      check_out("R8 hw rise");
      rd(14'h100, 2'd1, 32'(m_pend), "R8 pending follows input");
      set_hw(s, 1'b0);
      check_out("R8 hw fall");
    end
    set_hw(11, 1'b1);
    wr(14'h1C1, 32'h08, 2'd0); m_en[11] = 1'b1;
    check_out("R8 enable after pending");

    // R4 wedge sweep
    for (int s = 0; s < NS; s++) begin
      wr(14'h0004, 32'h8000_0000 | 32'(s), 2'd2); m_pend[s] = 1'b1;
      check_out("R4 wedge set");
      wr(14'h0004, 32'(s), 2'd2); m_pend[s] = 1'b0;
      check_out("R4 wedge clear");
    end
    wr(14'h0004, 32'h8000_0000 | 32'(NS), 2'd2);
    rd(14'h100, 2'd1, 32'(m_pend), "R4 out of range ignored");
    check_out("R4 out of range outputs");

    // R7 mixed traffic with OR-combined sources
    wr(14'h1C0, 32'hFFFF, 2'd1); m_en = '1;
    lfsr = 16'hACE1;
    for (int k = 0; k < 80; k++) begin
      int s;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      s = int'(lfsr[3:0]);
      if (k % 8 == 7) map_src(s, int'(lfsr[9:6]) % NP, int'(lfsr[10]));
      case (lfsr[5:4])
        2'd0: begin wr(14'h0004, 32'h8000_0000 | 32'(s), 2'd2); m_pend[s] = 1'b1; end
        2'd1: begin wr(14'h0004, 32'(s), 2'd2); m_pend[s] = 1'b0; end
        2'd2: begin wr(14'h1C0, 32'h1 << s, 2'd1); m_en[s] = 1'b1; end
        default: begin wr(14'h180, 32'h1 << s, 2'd1); m_en[s] = 1'b0; end
      endcase
      check_out("R7 combine");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule